// File: doc/BRIEF.md
# Byte-wide SPI controller with control register

This block is a serial peripheral port that moves 8-bit frames in either role. In master role it divides the system clock to make the serial clock and shifts one byte out while it shifts one byte in. In slave role it takes the serial clock, data and select from outside, brings them into its own clock domain and shifts its frame on those edges. Software reaches the block through a small register port: a control register, a status register and a data register.

The control register holds interrupt enable, pin enable, master select, clock polarity, clock phase and a three-bit rate code. A transfer starts when software writes the data register in master role. The end of a frame raises a completion flag. A byte that completes while the previous received byte is still unread raises an overrun flag. A low select input while the block is master raises a fault flag and takes the block off the pins. A single interrupt line reports any enabled flag.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, `irq_o` is low, and the three pin enables `sck_oe_o`, `mosi_oe_o`, `miso_oe_o` are low.
- R2: The control register at address 0 holds, from bit 7 down to bit 0: interrupt enable, pin enable, divider bypass (rate bit 2), master select, clock polarity, clock phase, rate bit 1, rate bit 0. It reads back what was written.
- R3: In master role each half period of `sck_o` lasts H system clocks, with H chosen by {bit5,bit1,bit0}: 100→2, 000→4, 001→8, 110→16, 010→32, 011→64, 101→4, 111→32. The first toggle comes H cycles after the data write.
- R4: In master role with no transfer under way, `sck_o` equals the clock polarity bit. Polarity 0 gives an idle-low clock and polarity 1 gives an idle-high clock.
- R5: With phase 0, data is captured on the first clock transition and on every second one after it. With phase 1, data is captured on the second transition and on every second one after it. The received byte equals the eight captured bits, MSB first, and the transmitted byte leaves MSB first.
- R6: A frame is 16 clock transitions. The completion flag (status bit 7) is set on the clock of the 16th transition. A data write while a master frame is under way is ignored.
- R7: If a frame completes while the received byte is unread, the overrun flag (status bit 6) is set and the data register keeps the older byte. A data read in the same cycle as the completion frees the buffer, so the new byte is stored and overrun stays clear.
- R8: In master role with pins enabled, a low `ss_ni` seen through a two-stage synchronizer sets the fault flag (status bit 5), clears the pin-enable and master-select bits, and aborts the frame.
- R9: A status read followed by a data-register access clears the completion and overrun flags. A status read followed by a control write clears the fault flag. The same access without the preceding status read clears nothing.
- R10: `irq_o` is high exactly when interrupt enable is set and at least one of the completion, overrun and fault flags is set.
- R11: `sck_oe_o` and `mosi_oe_o` are high only with pins enabled in master role. `miso_oe_o` is high only with pins enabled in slave role while the synchronized select is low.
- R12: In slave role the block shifts on the synchronized `sck_i` edges while `ss_ni` is low, captures `mosi_i`, drives `miso_o` MSB first, and the rate bits have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt request |
| ss_ni | input | 1 | Select input, active low |
| sck_i | input | 1 | Serial clock in slave role |
| sck_o | output | 1 | Serial clock in master role |
| sck_oe_o | output | 1 | Drive enable for the serial clock |
| mosi_i | input | 1 | Serial data in, slave role |
| mosi_o | output | 1 | Serial data out, master role |
| mosi_oe_o | output | 1 | Drive enable for master data out |
| miso_i | input | 1 | Serial data in, master role |
| miso_o | output | 1 | Serial data out, slave role |
| miso_oe_o | output | 1 | Drive enable for slave data out |

## Verification
The delicate coincidence is a frame completing on the same clock as a software read of the data register, since one event fills the receive buffer while the other empties it. The bench times a data read to land exactly on the edge of the 16th transition. It expects the older byte on the read, no overrun afterwards, the completion flag set, and the new byte in the register. A second coincidence, a fault during a running frame, is provoked by lowering the select input mid-frame. It is judged by the serial clock returning to idle and the control bits reading back cleared.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CB_IE   = 7;
  localparam int CB_OE   = 6;
  localparam int CB_DIV  = 5;
  localparam int CB_MST  = 4;
  localparam int CB_CPOL = 3;
  localparam int CB_CPHA = 2;

  localparam int SB_TC  = 7;
  localparam int SB_OVR = 6;
  localparam int SB_FLT = 5;

  // log2 of the half period; rate = {bypass, r1, r0}
  function automatic logic [2:0] half_exp(logic [2:0] rate);
    logic [2:0] base;
    case (rate[1:0])
      2'd0:    base = 3'd0;
      2'd1:    base = 3'd1;
      2'd2:    base = 3'd3;
      default: base = 3'd4;
    endcase
    return base + (rate[2] ? 3'd1 : 3'd2);
  endfunction
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ctl_baud.sv
module spi_ctl_baud
  import spi_ctl_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] rate_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = (CNT_W'(1) << half_exp(rate_i)) - CNT_W'(1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);

  // shortest half period is two clocks
  assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          edge_i,
  input  logic          clear_i,
  input  logic          cpha_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          ph_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  localparam int unsigned   IW   = $clog2(2 * DW);
  localparam logic [IW-1:0] LAST = IW'(2 * DW - 1);

  logic [DW-1:0] sr_q;
  logic [IW-1:0] idx_q;
  logic          lat_q, ph_q;
  logic          last, cap;

  assign last   = (idx_q == LAST);
  assign cap    = (idx_q[0] == cpha_i);
  assign rx_o   = {sr_q[DW-2:0], (cpha_i ? din_i : lat_q)};
  assign done_o = edge_i && last && !clear_i;
  assign dout_o = sr_q[DW-1];
  assign ph_o   = ph_q;
  assign busy_o = (idx_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
      lat_q <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      if (load_i) sr_q <= load_data_i;
      if (clear_i) begin
        idx_q <= '0;
        ph_q  <= 1'b0;
      end else if (edge_i) begin
        ph_q  <= ~ph_q;
        idx_q <= last ? '0 : idx_q + IW'(1);
        if (last)                          sr_q  <= rx_o;
        else if (cap)                      lat_q <= din_i;
        else if (!(cpha_i && idx_q == '0)) sr_q  <= {sr_q[DW-2:0], lat_q};
      end
    end

  // the clock level returns to idle at the end of every frame
  assert_frame_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !ph_q && !busy_o);
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  input  logic          ss_ni,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe_o,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe_o
);
  logic [DW-1:0] ctrl_q, rx_q, rx_new;
  logic tc_q, ovr_q, flt_q, arm_tc_q, arm_flt_q, rx_full_q, mst_busy_q, sck_d_q;
  logic ss_s, sck_s, mosi_s;
  logic wr_ctrl, rd_stat, wr_data, rd_data, data_acc;
  logic mstr, oe, fault_evt, start, load, tick, sh_edge, sh_clear, din;
  logic dout, ph, eng_busy, done, accept;

  spi_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({ss_ni, sck_i, mosi_i}),
    .q_o ({ss_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s;

  assign wr_ctrl  = reg_wr_i && (reg_addr_i == REG_CTRL);
  assign rd_stat  = reg_rd_i && (reg_addr_i == REG_STAT);
  assign wr_data  = reg_wr_i && (reg_addr_i == REG_DATA);
  assign rd_data  = reg_rd_i && (reg_addr_i == REG_DATA);
  assign data_acc = wr_data || rd_data;

  assign mstr      = ctrl_q[CB_MST];
  assign oe        = ctrl_q[CB_OE];
  assign fault_evt = mstr && oe && !ss_s;
  assign start     = wr_data && mstr && oe && !mst_busy_q && !fault_evt;
  assign load      = start || (wr_data && !mstr && !eng_busy);
  assign sh_edge   = mstr ? tick : (!ss_s && (sck_s ^ sck_d_q));
  assign sh_clear  = mstr ? fault_evt : ss_s;
  assign din       = mstr ? miso_i : mosi_s;

  spi_ctl_baud #(.CNT_W(CNT_W)) u_baud (
    .clk_i, .rst_ni,
    .run_i  (mst_busy_q),
    .rate_i ({ctrl_q[CB_DIV], ctrl_q[1:0]}),
    .tick_o (tick)
  );

  spi_ctl_shift #(.DW(DW)) u_shift (
    .clk_i, .rst_ni,
    .load_i      (load),
    .load_data_i (reg_wdata_i),
    .edge_i      (sh_edge),
    .clear_i     (sh_clear),
    .cpha_i      (ctrl_q[CB_CPHA]),
    .din_i       (din),
    .dout_o      (dout),
    .ph_o        (ph),
    .busy_o      (eng_busy),
    .done_o      (done),
    .rx_o        (rx_new)
  );

  // a read in the completion cycle frees the buffer for the new byte
  assign accept = done && !(rx_full_q && !rd_data);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctrl_q     <= '0;
      rx_q       <= '0;
      tc_q       <= 1'b0;
      ovr_q      <= 1'b0;
      flt_q      <= 1'b0;
      arm_tc_q   <= 1'b0;
      arm_flt_q  <= 1'b0;
      rx_full_q  <= 1'b0;
      mst_busy_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i;
      if (fault_evt) begin
        ctrl_q[CB_OE]  <= 1'b0;
        ctrl_q[CB_MST] <= 1'b0;
      end

      if (fault_evt || (mstr && done)) mst_busy_q <= 1'b0;
      else if (start)                  mst_busy_q <= 1'b1;

      if (done)                       tc_q <= 1'b1;
      else if (data_acc && arm_tc_q)  tc_q <= 1'b0;

      if (done && !accept)            ovr_q <= 1'b1;
      else if (data_acc && arm_tc_q)  ovr_q <= 1'b0;

      if (accept) begin
        rx_q      <= rx_new;
        rx_full_q <= 1'b1;
      end else if (rd_data) begin
        rx_full_q <= 1'b0;
      end

      if (fault_evt)                  flt_q <= 1'b1;
      else if (wr_ctrl && arm_flt_q)  flt_q <= 1'b0;

      if (rd_stat)       arm_tc_q <= tc_q;
      else if (data_acc) arm_tc_q <= 1'b0;

      if (rd_stat)      arm_flt_q <= flt_q;
      else if (wr_ctrl) arm_flt_q <= 1'b0;
    end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL: reg_rdata_o = ctrl_q;
      REG_STAT: begin
        reg_rdata_o[SB_TC]  = tc_q;
        reg_rdata_o[SB_OVR] = ovr_q;
        reg_rdata_o[SB_FLT] = flt_q;
      end
      REG_DATA: reg_rdata_o = rx_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o     = ctrl_q[CB_IE] && (tc_q || ovr_q || flt_q);
  assign sck_o     = ctrl_q[CB_CPOL] ^ ph;
  assign sck_oe_o  = oe && mstr;
  assign mosi_o    = dout;
  assign mosi_oe_o = oe && mstr;
  assign miso_o    = dout;
  assign miso_oe_o = oe && !mstr && !ss_s;

  assert_fault_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt |=> !ctrl_q[CB_OE] && !ctrl_q[CB_MST] && flt_q && !mst_busy_q);

  assert_ovr_keeps_old_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rx_full_q && !rd_data) |=> ovr_q && $stable(rx_q));

  assert_done_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> tc_q);

  assert_idle_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstr && !mst_busy_q) |-> (sck_o == ctrl_q[CB_CPOL]));
endmodule

// File: tb/spi_ctl_bench.sv
module spi_ctl_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd3;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, ss_n = 1'b1, sck_in = 1'b0, mosi_in = 1'b0, inv = 1'b0;
  logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_in, miso_out, miso_oe;

  int errors = 0, checks = 0, cycles = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign miso_in = mosi_out ^ inv;  // loopback, optionally inverted

  spi_ctl u_spi_ctl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq),
    .ss_ni(ss_n), .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
    .mosi_i(mosi_in), .mosi_o(mosi_out), .mosi_oe_o(mosi_oe),
    .miso_i(miso_in), .miso_o(miso_out), .miso_oe_o(miso_oe)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int half_of(logic [2:0] code);
    case (code)
      3'b100: return 2;
      3'b000: return 4;
      3'b001: return 8;
      3'b110: return 16;
      3'b010: return 32;
      3'b011: return 64;
      3'b101: return 4;
      default: return 32;
    endcase
  endfunction

  // ---------------- behavioural reference, master side ----------------
  bit [7:0] m_ctrl;
  bit m_tc, m_ovr, m_flt, m_arm_tc, m_arm_flt, m_rxfull, m_busy, m_ph, m_ss1, m_ss2;
  int m_cnt, m_edges;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_tc = 0; m_ovr = 0; m_flt = 0; m_arm_tc = 0; m_arm_flt = 0;
      m_rxfull = 0; m_busy = 0; m_ph = 0; m_ss1 = 1; m_ss2 = 1; m_cnt = 0; m_edges = 0;
    end else begin
      bit f_evt, done, drd, dacc, wctl, rstat;
      f_evt = m_ctrl[4] && m_ctrl[6] && !m_ss2;
      drd   = rd && addr == 2'd2;
      dacc  = drd || (wr && addr == 2'd2);
      wctl  = wr && addr == 2'd0;
      rstat = rd && addr == 2'd1;
      done  = 0;
      if (f_evt) begin
        m_busy = 0; m_ph = 0; m_edges = 0; m_cnt = 0;
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == half_of({m_ctrl[5], m_ctrl[1:0]})) begin
          m_cnt = 0; m_ph = !m_ph; m_edges++;
          if (m_edges == 16) begin done = 1; m_busy = 0; m_edges = 0; end
        end
      end else if (wr && addr == 2'd2 && m_ctrl[4] && m_ctrl[6]) begin
        m_busy = 1; m_cnt = 0; m_edges = 0;
      end
      if (done) m_ovr = m_ovr || (m_rxfull && !drd);
      else if (dacc && m_arm_tc) m_ovr = 0;
      if (done) m_tc = 1;
      else if (dacc && m_arm_tc) m_tc = 0;
      if (done) m_rxfull = 1;
      else if (drd) m_rxfull = 0;
      if (f_evt) m_flt = 1;
      else if (wctl && m_arm_flt) m_flt = 0;
      if (rstat) begin m_arm_tc = m_tc_prev(done); m_arm_flt = m_flt_prev; end
      else begin
        if (dacc) m_arm_tc = 0;
        if (wctl) m_arm_flt = 0;
      end
      m_flt_prev_upd();
      if (wctl) m_ctrl = wdata;
      if (f_evt) begin m_ctrl[6] = 0; m_ctrl[4] = 0; end
      m_ss2 = m_ss1; m_ss1 = ss_n;
    end
  end

  // arming samples the flag values from before this edge
  bit tc_hist, flt_hist;
  function automatic bit m_tc_prev(bit unused);
    return tc_hist;
  endfunction
  bit m_flt_prev;
  always_comb m_flt_prev = flt_hist;
  task automatic m_flt_prev_upd();
    tc_hist  = m_tc;
    flt_hist = m_flt;
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      if (m_ctrl[4]) chk("R3 sck_o per clock", sck_out, m_ctrl[3] ^ m_ph);
      chk("R11 sck_oe_o per clock", sck_oe, m_ctrl[6] && m_ctrl[4]);
      chk("R10 irq_o per clock", irq, m_ctrl[7] && (m_tc || m_ovr || m_flt));
    end
  end

  // ---------------- register access ----------------
  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 2'd3;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; addr = 2'd3;
  endtask

  task automatic master_xfer(logic [7:0] ctl, logic [7:0] tx, logic iv);
    logic [7:0] d;
    int k, h;
    h = half_of({ctl[5], ctl[1:0]});
    inv = iv;
    reg_write(2'd0, ctl);
    chk("R4 idle level before frame", sck_out, ctl[3]);
    reg_write(2'd2, tx);
    k = 0;
    while (sck_out == ctl[3] && k < 200) begin @(negedge clk); k++; end
    chk("R3 first half period", k, h);
    while (!irq) @(negedge clk);
    reg_read(2'd1, d);
    chk("R6 completion flag", d, 8'h80);
    reg_read(2'd2, d);
    chk("R5 received byte", d, tx ^ {8{iv}});
    chk("R9 flags cleared by status then data", irq, 0);
  endtask

  task automatic slave_frame(logic [7:0] ctl, logic [7:0] stx, logic [7:0] mrx);
    logic [7:0] d;
    reg_write(2'd0, ctl);
    reg_write(2'd2, stx);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 miso_oe_o while selected", miso_oe, 1);
    chk("R11 sck_oe_o in slave role", sck_oe, 0);
    for (int b = 7; b >= 0; b--) begin
      mosi_in = mrx[b];
      repeat (8) @(negedge clk);
      chk("R12 miso_o bit", miso_out, stx[b]);
      sck_in = 1'b1;
      repeat (8) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 miso_oe_o after release", miso_oe, 0);
    reg_read(2'd1, d);
    chk("R12 slave completion", d, 8'h80);
    reg_read(2'd2, d);
    chk("R12 slave received byte", d, mrx);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    // R1 reset state
    reg_read(2'd0, d); chk("R1 control after reset", d, 8'h00);
    reg_read(2'd1, d); chk("R1 status after reset", d, 8'h00);
    chk("R1 irq_o after reset", irq, 0);
    chk("R1 enables after reset", {sck_oe, mosi_oe, miso_oe}, 0);

    // R2 layout / read back, R4 idle high, R11 enables
    reg_write(2'd0, 8'h7F);
    reg_read(2'd0, d); chk("R2 control read back", d, 8'h7F);
    chk("R4 idle high", sck_out, 1);
    chk("R11 master enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    reg_write(2'd0, 8'h00);

    // R3 rate sweep with every polarity/phase combination, R5 data
    for (int i = 0; i < 8; i++) begin
      logic [2:0] code;
      logic [7:0] ctl;
      code = 3'(i);
      ctl = 8'hD0 | {2'b00, code[2], 1'b0, 1'(i % 2), 1'((i / 2) % 2), code[1:0]};
      master_xfer(ctl, 8'hA5 ^ 8'(i * 37), 1'(i / 4));
    end

    // R6 write during a frame is ignored
    inv = 1'b0;
    reg_write(2'd0, 8'hF0);
    reg_write(2'd2, 8'h3C);
    repeat (5) @(negedge clk);
    reg_write(2'd2, 8'hC3);
    while (!irq) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R6 no second frame", sck_out, 0);
    reg_read(2'd1, d); chk("R6 status after ignored write", d, 8'h80);
    reg_read(2'd2, d); chk("R6 first byte kept", d, 8'h3C);

    // R7 overrun keeps older byte; R9 clear
    inv = 1'b1;
    reg_write(2'd2, 8'h11);
    repeat (40) @(negedge clk);
    reg_write(2'd2, 8'h22);
    repeat (40) @(negedge clk);
    reg_read(2'd1, d); chk("R7 overrun flag", d, 8'hC0);
    reg_read(2'd2, d); chk("R7 older byte kept", d, 8'hEE);
    reg_read(2'd1, d); chk("R9 flags cleared", d, 8'h00);

    // R7 read in the completion cycle
    inv = 1'b0;
    reg_write(2'd2, 8'h5A);
    repeat (40) @(negedge clk);
    reg_write(2'd2, 8'h96);
    repeat (31) @(negedge clk);
    addr = 2'd2; rd = 1'b1;
    #1 chk("R7 old byte on coincident read", rdata, 8'h5A);
    @(negedge clk); rd = 1'b0; addr = 2'd3;
    reg_read(2'd1, d); chk("R7 no overrun on coincident read", d, 8'h80);
    reg_read(2'd2, d); chk("R7 new byte stored", d, 8'h96);
    reg_read(2'd1, d); chk("R9 completion cleared", d, 8'h00);

    // R8 mode fault mid-frame, R9 fault clear sequence
    reg_write(2'd0, 8'hF3);
    reg_write(2'd2, 8'h77);
    repeat (6) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    ss_n = 1'b1;
    reg_read(2'd0, d); chk("R8 control bits dropped", d, 8'hA3);
    chk("R8 pins released", {sck_oe, mosi_oe}, 0);
    chk("R10 irq on fault", irq, 1);
    repeat (300) @(negedge clk);
    chk("R8 frame aborted", sck_out, 0);
    reg_write(2'd0, 8'hA3);
    reg_read(2'd1, d); chk("R9 fault kept without status read", d, 8'h20);
    reg_write(2'd0, 8'h00);
    reg_read(2'd1, d); chk("R9 fault cleared", d, 8'h00);
    chk("R10 irq low after clear", irq, 0);

    // R12 slave role, two different rate codes
    slave_frame(8'h40, 8'hB4, 8'h6D);
    slave_frame(8'h63, 8'hB4, 8'h6D);

    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule